// File: doc/BRIEF.md
# 128-bit Integer Divide and Remainder Unit

This block divides one 128-bit integer by another over many clock cycles. It returns either the quotient or the remainder, in signed or unsigned form. Each operand arrives as two 64-bit halves, and the result leaves the same way. A single-cycle start strobe captures the operands and the operation code. The result is then held on the output halves, and a one-cycle done strobe marks it as valid.

Two inputs never enter the iteration, and neither raises a trap. The first is a zero divisor. The second is the signed quotient of the most negative 128-bit value by minus one. For both, the unit writes a fixed result in the cycle that accepts the start. Every other operation works on operand magnitudes. The unit negates the operands, runs a restoring shift-subtract loop that retires one quotient bit per cycle, and restores the sign at the end.

Top module: `div128_unit`

## Requirements
- R1: With `op_i` = 00 (signed quotient) or 01 (unsigned quotient) and a divisor of zero in both halves, the result is all ones in all 128 bits.
- R2: With `op_i` = 10 (signed remainder) or 11 (unsigned remainder) and a divisor of zero, the result equals the dividend.
- R3: With `op_i` = 00, a dividend of -2^127 (high half 0x8000000000000000, low half 0) and a divisor of all ones (-1), the result equals the dividend.
- R4: With `op_i` = 10 and the same two operands as in R3, the result is zero.
- R5: For a nonzero divisor, `op_i` = 01 returns floor(a/b) and `op_i` = 11 returns a mod b, with both operands taken as unsigned.
- R6: For a nonzero divisor and no R3 overflow, `op_i` = 00 returns the two's-complement quotient truncated toward zero. `op_i` = 10 returns the remainder, which carries the sign of the dividend.
- R7: A start that hits a special case (R1, R2 or R3) raises `done_o` after the clock edge that samples the start. Any other start raises it after the 131st edge, counting the sampling edge as the first.
- R8: `busy_o` is high from the edge after an accepted non-special start until the cycle in which `done_o` is raised. `done_o` is never high together with `busy_o`.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running operation still returns its own result with its own latency, and no second result follows.
- R10: Operands and results are split so that bits 63:0 travel on the low-half port and bits 127:64 on the high-half port.
- R11: After reset, `busy_o` and `done_o` are low and both result halves are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| op_i | input | 2 | 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder |
| dvd_lo_i | input | 64 | Dividend bits 63:0 |
| dvd_hi_i | input | 64 | Dividend bits 127:64 |
| dvs_lo_i | input | 64 | Divisor bits 63:0 |
| dvs_hi_i | input | 64 | Divisor bits 127:64 |
| busy_o | output | 1 | Iterating operation in progress |
| done_o | output | 1 | One-cycle result-valid strobe |
| res_lo_o | output | 64 | Result bits 63:0 |
| res_hi_o | output | 64 | Result bits 127:64 |

## Verification
Each result becomes due either one edge or 131 edges after the edge that samples the start. The count depends only on whether the operands form a special case, so the bench works out the expected figure from the operands alone. The bench drives the start half a cycle before a rising edge. It then counts falling edges until it sees done, and compares both the value and the edge count against its own model, so a result that arrives early or late fails even when its value is correct. The busy check is made at the first falling edge after the start. The check that no further result follows an ignored start is made over a window of falling edges after done.

// File: rtl/div128_pkg.sv
// Package div128_pkg
// Shared types for the 128-bit divide/remainder unit: operation codes,
// controller states and small helpers. Assumes op bit 1 selects the
// remainder and op bit 0 selects unsigned treatment.
package div128_pkg;

    typedef enum logic [1:0] {
        OP_DIV  = 2'b00,
        OP_DIVU = 2'b01,
        OP_REM  = 2'b10,
        OP_REMU = 2'b11
    } div_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PREP = 2'b01,
        ST_ITER = 2'b10,
        ST_FIX  = 2'b11
    } div_state_e;

    // True when the operation treats its operands as two's complement.
    function automatic logic op_signed(input logic [1:0] op);
        return ~op[0];
    endfunction

    // True when the operation returns the remainder.
    function automatic logic op_is_rem(input logic [1:0] op);
        return op[1];
    endfunction

endpackage

// File: rtl/div128_special.sv
// Module div128_special
// Spots the operand pairs that finish without iteration: a zero divisor
// for any operation, and the signed quotient overflow (most negative
// value divided by -1). Purely combinational; assumes the operands are
// the raw inputs of the cycle in which a start is taken.
module div128_special
    import div128_pkg::*;
#(
    parameter int W = 128
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         hit_o,
    output logic [W-1:0] value_o
);

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic dvs_zero;
    logic sgn_ovf;

    // Classify the operand pair and pick the fixed answer.
    always_comb begin
        dvs_zero = (dvs_i == '0);
        sgn_ovf  = (op_i == OP_DIV) && (dvd_i == MOST_NEG) && (dvs_i == '1);
        hit_o    = dvs_zero || sgn_ovf;
        if (dvs_zero && !op_is_rem(op_i)) begin
            value_o = '1;
        end else begin
            value_o = dvd_i;
        end
    end

endmodule

// File: rtl/div128_iter.sv
// Module div128_iter
// Restoring shift-subtract engine working on unsigned magnitudes. Each
// step retires one quotient bit; after W steps the quotient and the
// remainder are valid. Assumes the controller loads a nonzero divisor
// and issues exactly W steps after the load.
module div128_iter #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] dvd_mag_i,
    input  logic [W-1:0] dvs_mag_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         last_o
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = ~diff[W];
    end

    // Load the magnitudes, then shift one quotient bit in per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= dvd_mag_i;
            dvs_q <= dvs_mag_i;
            cnt_q <= '0;
        end else if (step_i) begin
            rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign quo_o  = quo_q;
    assign rem_o  = rem_q;
    assign last_o = (cnt_q == LAST_STEP);

    // Partial remainder always stays below a loaded nonzero divisor (R5, R6).
    p_rem_below_divisor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/div128_unit.sv
// Module div128_unit
// Top of the multi-cycle 128-bit divide/remainder unit. Takes operands
// as 64-bit halves, resolves special cases in the accepting cycle and
// otherwise sequences: operand negation, W iteration steps, result sign
// fix. Assumes start_i is a single-cycle strobe; starts while busy are
// dropped.
module div128_unit
    import div128_pkg::*;
#(
    parameter int HALF = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [HALF-1:0] dvd_lo_i,
    input  logic [HALF-1:0] dvd_hi_i,
    input  logic [HALF-1:0] dvs_lo_i,
    input  logic [HALF-1:0] dvs_hi_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [HALF-1:0] res_lo_o,
    output logic [HALF-1:0] res_hi_o
);

    localparam int W = 2 * HALF;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    div_state_e   state_q;
    logic [1:0]   op_q;
    logic [W-1:0] dvd_q;
    logic [W-1:0] dvs_q;
    logic [W-1:0] res_q;
    logic         done_q;

    logic [W-1:0] dvd_w;
    logic [W-1:0] dvs_w;
    logic         spec_hit;
    logic [W-1:0] spec_val;

    logic         a_neg;
    logic         b_neg;
    logic [W-1:0] a_mag;
    logic [W-1:0] b_mag;
    logic [W-1:0] quo_mag;
    logic [W-1:0] rem_mag;
    logic         iter_last;
    logic [W-1:0] pick;
    logic         flip;
    logic [W-1:0] fixed_res;

    assign dvd_w = {dvd_hi_i, dvd_lo_i};
    assign dvs_w = {dvs_hi_i, dvs_lo_i};

    div128_special #(.W(W)) u_special (
        .op_i    (op_i),
        .dvd_i   (dvd_w),
        .dvs_i   (dvs_w),
        .hit_o   (spec_hit),
        .value_o (spec_val)
    );

    // Operand signs and magnitudes from the captured operands.
    always_comb begin
        a_neg = op_signed(op_q) & dvd_q[W-1];
        b_neg = op_signed(op_q) & dvs_q[W-1];
        a_mag = a_neg ? (~dvd_q + 1'b1) : dvd_q;
        b_mag = b_neg ? (~dvs_q + 1'b1) : dvs_q;
    end

    div128_iter #(.W(W)) u_iter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (state_q == ST_PREP),
        .step_i    (state_q == ST_ITER),
        .dvd_mag_i (a_mag),
        .dvs_mag_i (b_mag),
        .quo_o     (quo_mag),
        .rem_o     (rem_mag),
        .last_o    (iter_last)
    );

    // Select quotient or remainder and restore its sign.
    always_comb begin
        pick      = op_is_rem(op_q) ? rem_mag : quo_mag;
        flip      = op_is_rem(op_q) ? a_neg : (a_neg ^ b_neg);
        fixed_res = flip ? (~pick + 1'b1) : pick;
    end

    // Controller: accept, prepare, iterate, fix sign, publish result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            dvd_q   <= '0;
            dvs_q   <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q  <= op_i;
                        dvd_q <= dvd_w;
                        dvs_q <= dvs_w;
                        if (spec_hit) begin
                            res_q  <= spec_val;
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_PREP;
                        end
                    end
                end
                ST_PREP: state_q <= ST_ITER;
                ST_ITER: begin
                    if (iter_last) begin
                        state_q <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    res_q   <= fixed_res;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign res_lo_o = res_q[HALF-1:0];
    assign res_hi_o = res_q[W-1:HALF];

    // Zero divisor on a quotient gives all ones one edge later (R1).
    p_zero_quot_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && dvs_w == '0 && !op_i[1]) |=> (done_o && {res_hi_o, res_lo_o} == '1));

    // Zero divisor on a remainder passes the dividend through (R2).
    p_zero_rem_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && dvs_w == '0 && op_i[1]) |=> (done_o && {res_hi_o, res_lo_o} == $past(dvd_w)));

    // Signed quotient overflow returns the dividend (R3).
    p_ovf_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && op_i == OP_DIV && dvd_w == MOST_NEG && dvs_w == '1)
        |=> (done_o && {res_hi_o, res_lo_o} == MOST_NEG));

    // Signed remainder of the most negative value by -1 is zero (R4).
    p_min_rem_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX && op_q == OP_REM && dvd_q == MOST_NEG && dvs_q == '1)
        |=> (done_o && {res_hi_o, res_lo_o} == '0));

    // Done and busy never overlap (R8).
    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // Busy ends only by publishing a result (R8).
    p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // A start while busy leaves the captured operation untouched (R9).
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(op_q) && $stable(dvd_q) && $stable(dvs_q)));

endmodule

// File: tb/sim_div128_unit.sv
`timescale 1ns/1ps
module sim_div128_unit;

    localparam int HALF     = 64;
    localparam int W        = 128;
    localparam int LAT_NORM = 131;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [1:0]      op_i = '0;
    logic [HALF-1:0] dvd_lo_i = '0, dvd_hi_i = '0, dvs_lo_i = '0, dvs_hi_i = '0;
    logic            busy_o, done_o;
    logic [HALF-1:0] res_lo_o, res_hi_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    div128_unit #(.HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .dvd_lo_i(dvd_lo_i), .dvd_hi_i(dvd_hi_i),
        .dvs_lo_i(dvs_lo_i), .dvs_hi_i(dvs_hi_i),
        .busy_o(busy_o), .done_o(done_o),
        .res_lo_o(res_lo_o), .res_hi_o(res_hi_o)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit special(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        return (b == '0) || (op == 2'b00 && a == MOST_NEG && b == '1);
    endfunction

    function automatic logic [W-1:0] model(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        if (b == '0) return op[1] ? a : '1;
        if (a == MOST_NEG && b == '1 && op == 2'b00) return a;
        if (a == MOST_NEG && b == '1 && op == 2'b10) return '0;
        case (op)
            2'b00:   return $signed(a) / $signed(b);
            2'b01:   return a / b;
            2'b10:   return $signed(a) % $signed(b);
            default: return a % b;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        if (b == '0) return op[1] ? "R2 zero-divisor remainder" : "R1 zero-divisor quotient";
        if (a == MOST_NEG && b == '1 && op == 2'b00) return "R3 signed overflow";
        if (a == MOST_NEG && b == '1 && op == 2'b10) return "R4 min rem -1";
        return op[0] ? "R5 unsigned" : "R6 signed";
    endfunction

    function automatic logic [W-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Issue one operation, wait for done, report value and edge count.
    task automatic run(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] got, output int lat, output bit busy_seen);
        @(negedge clk);
        start_i = 1'b1;
        op_i = op;
        {dvd_hi_i, dvd_lo_i} = a;
        {dvs_hi_i, dvs_lo_i} = b;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        busy_seen = busy_o;
        while (!done_o && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        got = {res_hi_o, res_lo_o};
        chk(!busy_o, "R8 busy low at done", {127'd0, busy_o}, '0);
    endtask

    task automatic do_case(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] got;
        int lat;
        bit bs;
        bit sp;
        sp = special(op, a, b);
        run(op, a, b, got, lat, bs);
        chk(got == model(op, a, b), tag_of(op, a, b), got, model(op, a, b));
        chk(lat == (sp ? 1 : LAT_NORM), "R7 latency", W'(lat), W'(sp ? 1 : LAT_NORM));
        if (!sp) chk(bs == 1'b1, "R8 busy after start", {127'd0, bs}, W'(1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R7 actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] got;
        int lat;
        bit bs;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy_o && !done_o, "R11 reset flags", {126'd0, busy_o, done_o}, '0);
        chk({res_hi_o, res_lo_o} == '0, "R11 reset result", {res_hi_o, res_lo_o}, '0);

        // Directed corner cases
        do_case(2'b00, 128'h1234, '0);                 // R1
        do_case(2'b01, rnd128(), '0);                  // R1
        do_case(2'b10, 128'hdead_beef_0000_0001, '0);  // R2
        do_case(2'b11, rnd128(), '0);                  // R2
        do_case(2'b00, MOST_NEG, '1);                  // R3
        do_case(2'b10, MOST_NEG, '1);                  // R4
        do_case(2'b01, MOST_NEG, '1);                  // R5 unsigned on same bits
        do_case(2'b00, -128'sd7, 128'sd2);             // R6 truncation toward zero
        do_case(2'b10, -128'sd7, 128'sd2);             // R6 remainder sign
        do_case(2'b10, 128'sd7, -128'sd2);             // R6
        do_case(2'b00, MOST_NEG, 128'sd2);             // R6
        do_case(2'b11, 128'd5, 128'd9);                // R5 divisor larger

        // R10 half split: unsigned divide by one passes both halves
        run(2'b01, {64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210}, 128'd1, got, lat, bs);
        chk(res_lo_o == 64'hfedc_ba98_7654_3210, "R10 low half", W'(res_lo_o), W'(64'hfedc_ba98_7654_3210));
        chk(res_hi_o == 64'h0123_4567_89ab_cdef, "R10 high half", W'(res_hi_o), W'(64'h0123_4567_89ab_cdef));
        // R10 divisor in the high half only
        do_case(2'b01, {64'd10, 64'd0}, {64'd2, 64'd0});

        // R9 start while busy is ignored
        @(negedge clk);
        start_i = 1'b1; op_i = 2'b01;
        {dvd_hi_i, dvd_lo_i} = 128'd1000;
        {dvs_hi_i, dvs_lo_i} = 128'd7;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        repeat (10) begin @(negedge clk); lat++; end
        start_i = 1'b1; op_i = 2'b00;
        {dvd_hi_i, dvd_lo_i} = 128'd50;
        {dvs_hi_i, dvs_lo_i} = '0;
        @(negedge clk);
        lat++;
        start_i = 1'b0;
        while (!done_o && lat < 400) begin @(negedge clk); lat++; end
        chk({res_hi_o, res_lo_o} == 128'd142, "R9 result of first op", {res_hi_o, res_lo_o}, 128'd142);
        chk(lat == LAT_NORM, "R9 latency unchanged", W'(lat), W'(LAT_NORM));
        bs = 1'b0;
        repeat (140) begin
            @(negedge clk);
            if (done_o || busy_o) bs = 1'b1;
        end
        chk(!bs, "R9 no second result", {127'd0, bs}, '0);

        // Constrained random mix
        for (int i = 0; i < 48; i++) begin
            logic [1:0]   op;
            logic [W-1:0] a;
            logic [W-1:0] b;
            op = 2'($urandom % 4);
            a  = rnd128() >> ($urandom % 40);
            case ($urandom % 3)
                0:       b = rnd128();
                1:       b = rnd128() >> (($urandom % 120) + 4);
                default: b = -(rnd128() >> (($urandom % 120) + 4));
            endcase
            if ($urandom % 2 == 0) a = -a;
            do_case(op, a, b);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule